// File: doc/BRIEF.md
# Cascadable Presettable Up/Down Counter

This block is a small synchronous binary counter whose state can be preset from a parallel data bus. It counts up or down under a direction input. Every state bit changes on the same rising clock edge, so the bits never ripple against each other. Two active-low enables control counting. The parallel enable is shared by every stage of a chain. The trickle enable is fed forward into an active-low carry output.

To build a wider counter, instantiate several stages on one clock and one parallel enable. Connect the carry output of each stage to the trickle enable of the stage above it. The carry goes low only when the trickle enable is low and the count sits at its terminal value for the current direction. A higher stage therefore steps exactly when every stage below it wraps, and no extra gating is needed. There is no reset: the state becomes known through the first synchronous load.

Top module: `updown_counter_stage`

## Requirements
- R1: When `loadN` is low at a rising clock edge, `count` takes the value of `data` after that edge.
- R2: A load takes priority over counting. With `loadN` low, `data` is loaded even when both enables are low, and no step is applied.
- R3: With `loadN` high, the count changes only when `enParN` and `enTrickN` are both low at the edge. Otherwise it holds its value.
- R4: With `countUp` high, an enabled edge adds one modulo 2^WIDTH, so the maximum value (15 at WIDTH=4) wraps to 0.
- R5: With `countUp` low, an enabled edge subtracts one modulo 2^WIDTH, so 0 wraps to the maximum value.
- R6: `carryN` is combinational. It is 0 exactly when `enTrickN` is 0 and `count` is at the terminal value for the current direction: all ones when `countUp` is 1, zero when `countUp` is 0. In every other case it is 1.
- R7: `enParN` has no effect on `carryN`.
- R8: Changes on `loadN`, `data`, the enables or `countUp` between edges leave `count` unchanged until the next rising edge.
- R9: Two stages sharing the clock, `loadN` and `enParN`, with the lower stage's `carryN` driving the upper stage's `enTrickN`, behave as one 2·WIDTH-bit up/down counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the state updates on its rising edge |
| loadN | input | 1 | Active-low synchronous parallel load |
| data | input | WIDTH | Parallel preset value |
| enParN | input | 1 | Active-low parallel count enable |
| enTrickN | input | 1 | Active-low trickle enable; also gates the carry |
| countUp | input | 1 | Direction: 1 counts up, 0 counts down |
| count | output | WIDTH | Current count |
| carryN | output | 1 | Active-low ripple carry at the terminal count |

## Verification
The hardest case to reach from the ports is a carry into the upper stage of a cascade in the down direction. The lower stage must sit at zero with its trickle enable low while the direction is held down, and the upper stage must then step at that same edge. The bench drives this by preloading the chain at values just above and below the 8-bit boundaries. It then runs long random stretches with mixed directions and parallel-enable pauses, so that borrows and carries across the stage boundary occur many times, including reversals that happen right at a terminal count.

// File: rtl/ucnt_pkg.sv
package ucnt_pkg;
  typedef struct packed {
    logic load;   // take the parallel data
    logic step;   // advance by one
    logic up;     // step direction
  } ctrlStrobe_t;
endpackage

// File: rtl/ucnt_ctrl.sv
module ucnt_ctrl
  import ucnt_pkg::*;
(
  input  logic        clk,
  input  logic        loadN,
  input  logic        enParN,
  input  logic        enTrickN,
  input  logic        countUp,
  input  logic        atMax,
  input  logic        atZero,
  output ctrlStrobe_t strobe,
  output logic        carryN
);
  logic terminalHit;

  always_comb begin
    strobe.load = ~loadN;
    strobe.step = loadN & ~enParN & ~enTrickN;
    strobe.up   = countUp;
  end

  always_comb begin
    terminalHit = countUp ? atMax : atZero;
    carryN      = ~(~enTrickN & terminalHit);
  end

  // R6: an asserted carry always needs the trickle enable
  p_carry_needs_trickle_r6: assert property (@(posedge clk)
    disable iff ($isunknown({atMax, atZero}))
    !carryN |-> !enTrickN);

  // R2: load and step are never both requested
  p_load_excl_step_r2: assert property (@(posedge clk)
    disable iff ($isunknown({loadN, enParN, enTrickN}))
    !(strobe.load && strobe.step));
endmodule

// File: rtl/ucnt_datapath.sv
module ucnt_datapath
  import ucnt_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  ctrlStrobe_t      strobe,
  input  logic [WIDTH-1:0] dataIn,
  output logic [WIDTH-1:0] countQ,
  output logic             atMax,
  output logic             atZero
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  logic [WIDTH-1:0] countNext;

  always_comb begin
    if (strobe.load)
      countNext = dataIn;
    else if (strobe.step)
      countNext = strobe.up ? countQ + ONE : countQ - ONE;
    else
      countNext = countQ;
  end

  always_ff @(posedge clk) countQ <= countNext;

  always_comb begin
    atMax  = &countQ;
    atZero = ~|countQ;
  end

  // R1: loaded value appears after the edge
  p_load_r1: assert property (@(posedge clk)
    disable iff ($isunknown(dataIn) || $isunknown(strobe))
    strobe.load |=> countQ == $past(dataIn));

  // R3: hold when neither load nor step
  p_hold_r3: assert property (@(posedge clk)
    disable iff ($isunknown(countQ) || $isunknown(strobe))
    (!strobe.load && !strobe.step) |=> $stable(countQ));

  // R4: up-step wraps from all ones to zero
  p_up_wrap_r4: assert property (@(posedge clk)
    disable iff ($isunknown(countQ) || $isunknown(strobe))
    (strobe.step && strobe.up && atMax) |=> atZero);

  // R5: down-step wraps from zero to all ones
  p_down_wrap_r5: assert property (@(posedge clk)
    disable iff ($isunknown(countQ) || $isunknown(strobe))
    (strobe.step && !strobe.up && atZero) |=> atMax);
endmodule

// File: rtl/updown_counter_stage.sv
module updown_counter_stage
  import ucnt_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             loadN,
  input  logic [WIDTH-1:0] data,
  input  logic             enParN,
  input  logic             enTrickN,
  input  logic             countUp,
  output logic [WIDTH-1:0] count,
  output logic             carryN
);
  ctrlStrobe_t strobe;
  logic        atMax;
  logic        atZero;

  ucnt_ctrl u_ctrl (
    .clk      (clk),
    .loadN    (loadN),
    .enParN   (enParN),
    .enTrickN (enTrickN),
    .countUp  (countUp),
    .atMax    (atMax),
    .atZero   (atZero),
    .strobe   (strobe),
    .carryN   (carryN)
  );

  ucnt_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk    (clk),
    .strobe (strobe),
    .dataIn (data),
    .countQ (count),
    .atMax  (atMax),
    .atZero (atZero)
  );

  // R6: carry in the up direction only at all ones
  p_carry_up_term_r6: assert property (@(posedge clk)
    disable iff ($isunknown(count))
    (!carryN && countUp) |-> count == {WIDTH{1'b1}});

  // R6: carry in the down direction only at zero
  p_carry_down_term_r6: assert property (@(posedge clk)
    disable iff ($isunknown(count))
    (!carryN && !countUp) |-> count == '0);
endmodule

// File: tb/updown_counter_stage_tb.sv
module updown_counter_stage_tb;
  localparam int PERIOD = 10;
  localparam int W = 4;

  logic clk = 1'b0;
  always #(PERIOD/2) clk = ~clk;

  int checks = 0;
  int fails  = 0;

  // standalone stage
  logic         loadN = 1'b1, enParN = 1'b1, enTrickN = 1'b1, countUp = 1'b1;
  logic [W-1:0] data = '0;
  logic [W-1:0] count;
  logic         carryN;

  updown_counter_stage #(.WIDTH(W)) u_dut (
    .clk(clk), .loadN(loadN), .data(data), .enParN(enParN),
    .enTrickN(enTrickN), .countUp(countUp), .count(count), .carryN(carryN));

  // two-stage cascade
  logic         cLoadN = 1'b1, cEnParN = 1'b1, cEnTrickN = 1'b1, cUp = 1'b1;
  logic [7:0]   cData = '0;
  logic [W-1:0] loCount, hiCount;
  logic         loCarryN, hiCarryN;

  updown_counter_stage #(.WIDTH(W)) u_lo (
    .clk(clk), .loadN(cLoadN), .data(cData[3:0]), .enParN(cEnParN),
    .enTrickN(cEnTrickN), .countUp(cUp), .count(loCount), .carryN(loCarryN));
  updown_counter_stage #(.WIDTH(W)) u_hi (
    .clk(clk), .loadN(cLoadN), .data(cData[7:4]), .enParN(cEnParN),
    .enTrickN(loCarryN), .countUp(cUp), .count(hiCount), .carryN(hiCarryN));

  function automatic logic [W-1:0] nextCount(logic [W-1:0] cur, logic ld,
      logic [W-1:0] d, logic ep, logic et, logic up);
    if (!ld) return d;
    if (!ep && !et) return up ? cur + 4'd1 : cur - 4'd1;
    return cur;
  endfunction

  function automatic logic expCarry(logic [W-1:0] cur, logic et, logic up);
    logic term;
    term = up ? (cur == 4'hF) : (cur == 4'h0);
    return !(!et && term);
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // advance one edge and land 2 time units after it
  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  logic [W-1:0] expCnt;
  logic [7:0]   exp8;

  initial begin
    #(PERIOD*100000);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    #3;
    // R1: initialise through a synchronous load
    loadN = 0; data = 4'd7;
    tick();
    chk("R1 initial load", count, 7);
    expCnt = 4'd7;

    // R2: load wins over both enables
    loadN = 0; data = 4'd3; enParN = 0; enTrickN = 0; countUp = 1;
    tick();
    chk("R2 load priority", count, 3);
    expCnt = 4'd3;

    // R3: one enable high -> hold
    loadN = 1; enParN = 1; enTrickN = 0;
    tick(); chk("R3 hold parallel high", count, 3);
    enParN = 0; enTrickN = 1;
    tick(); chk("R3 hold trickle high", count, 3);

    // R4: up wrap
    loadN = 0; data = 4'hF; tick();
    loadN = 1; enParN = 0; enTrickN = 0; countUp = 1;
    #1 chk("R6 carry up at 15", carryN, 0);
    tick(); chk("R4 wrap 15->0", count, 0);
    // R5: down wrap
    countUp = 0;
    #1 chk("R6 carry down at 0", carryN, 0);
    tick(); chk("R5 wrap 0->15", count, 15);
    // R6: direction mismatch gives no carry
    #1 chk("R6 no carry at 15 down", carryN, 1);
    // R7: parallel enable does not affect carry
    countUp = 1; enParN = 1;
    #1 chk("R7 carry with parallel high", carryN, 0);
    enTrickN = 1;
    #1 chk("R6 carry gated by trickle", carryN, 1);
    expCnt = 4'hF;

    // R8: mid-cycle changes do not touch the count
    loadN = 0; data = 4'd9; enParN = 0; enTrickN = 0;
    #1 chk("R8 load not yet applied", count, 15);
    loadN = 1; countUp = 0;
    #1 chk("R8 enables not yet applied", count, 15);
    enParN = 1;
    tick(); chk("R8 after edge with hold", count, 15);

    // random stimulus against the model
    for (int i = 0; i < 400; i++) begin
      loadN    = ($urandom_range(7) != 0);
      data     = W'($urandom);
      enParN   = ($urandom_range(3) == 0);
      enTrickN = ($urandom_range(3) == 0);
      countUp  = $urandom_range(1);
      #1 chk("R6 random carry", carryN, expCarry(expCnt, enTrickN, countUp));
      expCnt = nextCount(expCnt, loadN, data, enParN, enTrickN, countUp);
      tick();
      chk("R3 random count", count, expCnt);
    end

    // R9: cascade, directed boundary preloads then random run
    cEnParN = 0; cEnTrickN = 0;
    foreach (cData[k]) ;
    for (int s = 0; s < 4; s++) begin
      cLoadN = 0;
      cData  = (s == 0) ? 8'h0E : (s == 1) ? 8'h11 : (s == 2) ? 8'hFE : 8'h01;
      tick();
      chk("R9 cascade load", {hiCount, loCount}, cData);
      exp8 = cData;
      cLoadN = 1;
      cUp = (s % 2 == 0);
      for (int j = 0; j < 4; j++) begin
        exp8 = cUp ? exp8 + 8'd1 : exp8 - 8'd1;
        tick();
        chk("R9 cascade boundary", {hiCount, loCount}, exp8);
      end
    end
    for (int i = 0; i < 600; i++) begin
      cUp     = ($urandom_range(15) != 0) ? cUp : ~cUp;
      cEnParN = ($urandom_range(5) == 0);
      cLoadN  = ($urandom_range(63) != 0);
      cData   = 8'($urandom);
      if (!cLoadN) exp8 = cData;
      else if (!cEnParN) exp8 = cUp ? exp8 + 8'd1 : exp8 - 8'd1;
      tick();
      chk("R9 cascade random", {hiCount, loCount}, exp8);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule